// File: doc/BRIEF.md
# Coarse-Code Histogram Collector

This block builds code-density histograms for a 14-bit converter while a test ramp sweeps its input. Only the most significant bits of each output code choose a bin, so a small memory of 256 counters is enough. A downstream processor reads the counters once an acquisition has finished.

The block has two modes. In identification mode the top seven code bits choose one of 128 bins. A ramp-select input picks which half of the memory takes the sample. This gives two separate 128-bin histograms, one for the original ramp and one for the offset-shifted ramp. In characterization mode the top eight bits choose one of 256 bins, and the same memory holds a single histogram.

A clear command wipes the memory one word per cycle. A start command fixes the mode and ramp half and loads the number of samples to collect. Counting runs through a pipelined read-modify-write with forwarding, and the done flag rises once the last counted sample has been written.

Top module: `msb_histogram`

## Requirements
- R1: After reset the done flag is low, and samples presented while no acquisition is running are not counted.
- R2: A clear pulse writes zero to all 256 counters, one address per cycle, taking 256 cycles. Samples presented during that time are not counted.
- R3: In identification mode the counter address is {ramp select, code[13:7]}, where code bit 13 is the MSB. Ramp select 0 uses addresses 0x00–0x7F and ramp select 1 uses 0x80–0xFF.
- R4: In characterization mode the counter address is code[13:6], and the ramp select has no effect.
- R5: Every accepted sample increments its counter by one, including samples in the same bin on consecutive cycles and interleaved runs of two bins.
- R6: Counters are 16 bits wide and stop at 65535 instead of wrapping.
- R7: An acquisition counts exactly the programmed number of valid samples. Cycles with valid low are not counted, and later samples are ignored. Done stays low until the last counted value is in memory, then stays high until the next start or clear.
- R8: The read port returns the counter at the address presented one clock edge earlier.
- R9: The mode and ramp select are captured at start; changing them during an acquisition has no effect on addressing.
- R10: A clear during an acquisition abandons it. Done stays low and the memory ends up all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Pulse: zero all counters |
| start_i | input | 1 | Pulse: begin an acquisition (accepted when idle or done) |
| char_mode_i | input | 1 | 0 = identification (7-bit bins), 1 = characterization (8-bit bins) |
| ramp_sel_i | input | 1 | Identification half: 0 = original ramp, 1 = shifted ramp |
| target_i | input | 20 | Number of samples to collect |
| smp_valid_i | input | 1 | Sample strobe |
| smp_code_i | input | 14 | Converter output code, bit 13 is MSB |
| rd_addr_i | input | 8 | Counter read address |
| rd_data_o | output | 16 | Counter value, one cycle after address |
| done_o | output | 1 | Acquisition complete |

## Verification
A table of single samples walks both modes, both ramp halves and codes at the range ends and mid-scale. For each sample the bench reads the bin the address rule selects, and also the bin the other mode or ramp half would have chosen. This separates a wrong bit slice or a missing ramp bit from a correct one. Runs of one bin on consecutive cycles, and interleaved runs of two bins, show whether the forwarding path drops updates. A long run in one bin shows saturation against wrapping. Gapped strobes and surplus samples show whether the sample count stops at the target.

// File: rtl/mh_pkg.sv
package mh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLR   = 3'd1,
        ST_ACQ   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } mh_state_e;
endpackage

// File: rtl/mh_bin_map.sv
module mh_bin_map #(
    parameter int CODE_W = 14,
    parameter int ADDR_W = 8
) (
    input  logic              char_i,
    input  logic              ramp_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HALF_W = ADDR_W - 1;

    always_comb begin
        if (char_i) addr_o = code_i[CODE_W-1 -: ADDR_W];
        else        addr_o = {ramp_i, code_i[CODE_W-1 -: HALF_W]};
    end
endmodule

// File: rtl/mh_ctrl.sv
module mh_ctrl
    import mh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TGT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              start_i,
    input  logic              char_mode_i,
    input  logic              ramp_sel_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic              smp_valid_i,
    input  logic              pipe_busy_i,
    output logic              accept_o,
    output logic              char_o,
    output logic              ramp_o,
    output logic              clr_we_o,
    output logic [ADDR_W-1:0] clr_addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        mh_state_e         st;
        logic [ADDR_W-1:0] ptr;
        logic [TGT_W-1:0]  cnt;
        logic [TGT_W-1:0]  tgt;
        logic              chr;
        logic              ramp;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [TGT_W-1:0] cnt_inc;

    always_comb begin
        ctl_d    = ctl_q;
        accept_o = 1'b0;
        cnt_inc  = ctl_q.cnt + 1'b1;
        unique case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    ctl_d.cnt  = '0;
                    ctl_d.tgt  = target_i;
                    ctl_d.chr  = char_mode_i;
                    ctl_d.ramp = ramp_sel_i;
                    ctl_d.st   = (target_i == '0) ? ST_DRAIN : ST_ACQ;
                end
            end
            ST_CLR: begin
                ctl_d.ptr = ctl_q.ptr + 1'b1;
                if (ctl_q.ptr == LAST_ADDR) ctl_d.st = ST_IDLE;
            end
            ST_ACQ: begin
                if (smp_valid_i) begin
                    accept_o  = 1'b1;
                    ctl_d.cnt = cnt_inc;
                    if (cnt_inc == ctl_q.tgt) ctl_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!pipe_busy_i) ctl_d.st = ST_DONE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (clear_i) begin
            ctl_d.st  = ST_CLR;
            ctl_d.ptr = '0;
            accept_o  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign char_o     = ctl_q.chr;
    assign ramp_o     = ctl_q.ramp;
    assign clr_we_o   = (ctl_q.st == ST_CLR);
    assign clr_addr_o = ctl_q.ptr;
    assign done_o     = (ctl_q.st == ST_DONE);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ACQ) |-> (ctl_q.cnt < ctl_q.tgt));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i && !clear_i) |=> done_o);

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !done_o);
endmodule

// File: rtl/mh_rmw_pipe.sv
module mh_rmw_pipe #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_we_i,
    input  logic [ADDR_W-1:0] clr_addr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              busy_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              v1;
        logic [ADDR_W-1:0] a1;
        logic              v2;
        logic [ADDR_W-1:0] a2;
        logic [CNT_W-1:0]  d2;
        logic [CNT_W-1:0]  rd;
    } pipe_t;

    pipe_t pp_d, pp_q;
    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] old_val;

    always_comb begin
        pp_d    = pp_q;
        pp_d.v1 = accept_i;
        pp_d.a1 = addr_i;
        // forward the value still waiting to be written
        old_val = (pp_q.v2 && (pp_q.a2 == pp_q.a1)) ? pp_q.d2 : mem[pp_q.a1];
        pp_d.v2 = pp_q.v1;
        pp_d.a2 = pp_q.a1;
        pp_d.d2 = (old_val == CNT_MAX) ? old_val : old_val + 1'b1;
        if (flush_i) begin
            pp_d.v1 = 1'b0;
            pp_d.v2 = 1'b0;
        end
        pp_d.rd = mem[rd_addr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    // storage has no reset; a clear pass initialises it
    always_ff @(posedge clk) begin
        if (clr_we_i)     mem[clr_addr_i] <= '0;
        else if (pp_q.v2) mem[pp_q.a2]    <= pp_q.d2;
    end

    assign rd_data_o = pp_q.rd;
    assign busy_o    = pp_q.v1 | pp_q.v2;

    // R2
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |-> !(pp_q.v1 || pp_q.v2));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_q.v2 |-> (pp_q.d2 != '0));
endmodule

// File: rtl/msb_histogram.sv
module msb_histogram #(
    parameter int CODE_W = 14,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int TGT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              start_i,
    input  logic              char_mode_i,
    input  logic              ramp_sel_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic              smp_valid_i,
    input  logic [CODE_W-1:0] smp_code_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              done_o
);
    logic              accept;
    logic              chr;
    logic              ramp;
    logic              clr_we;
    logic [ADDR_W-1:0] clr_addr;
    logic [ADDR_W-1:0] bin_addr;
    logic              busy;

    mh_ctrl #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
        .char_mode_i(char_mode_i), .ramp_sel_i(ramp_sel_i), .target_i(target_i),
        .smp_valid_i(smp_valid_i), .pipe_busy_i(busy), .accept_o(accept),
        .char_o(chr), .ramp_o(ramp), .clr_we_o(clr_we), .clr_addr_o(clr_addr),
        .done_o(done_o)
    );

    mh_bin_map #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) i_map (
        .char_i(chr), .ramp_i(ramp), .code_i(smp_code_i), .addr_o(bin_addr)
    );

    mh_rmw_pipe #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_pipe (
        .clk(clk), .rst_n(rst_n), .flush_i(clear_i), .accept_i(accept),
        .addr_i(bin_addr), .clr_we_i(clr_we), .clr_addr_i(clr_addr),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy)
    );
endmodule

// File: tb/test_msb_histogram.sv
module test_msb_histogram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        start_i = 1'b0;
    logic        char_mode_i = 1'b0;
    logic        ramp_sel_i = 1'b0;
    logic [19:0] target_i = '0;
    logic        smp_valid_i = 1'b0;
    logic [13:0] smp_code_i = '0;
    logic [7:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    msb_histogram i_msb_histogram (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
        .char_mode_i(char_mode_i), .ramp_sel_i(ramp_sel_i), .target_i(target_i),
        .smp_valid_i(smp_valid_i), .smp_code_i(smp_code_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .done_o(done_o)
    );

    // {mode, ramp, code[13:0], expected bin, bin of the other mapping}
    localparam logic [31:0] VEC [8] = '{
        {1'b0, 1'b0, 14'h0000, 8'h00, 8'h80},
        {1'b0, 1'b1, 14'h0000, 8'h80, 8'h00},
        {1'b0, 1'b0, 14'h3FFF, 8'h7F, 8'hFF},
        {1'b0, 1'b1, 14'h2080, 8'hC1, 8'h82},
        {1'b1, 1'b0, 14'h3FFF, 8'hFF, 8'h7F},
        {1'b1, 1'b0, 14'h2080, 8'h82, 8'h41},
        {1'b1, 1'b1, 14'h0040, 8'h01, 8'h80},
        {1'b0, 1'b0, 14'h007F, 8'h00, 8'h01}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [13:0] code);
        @(negedge clk);
        smp_valid_i = v;
        smp_code_i  = code;
    endtask

    task automatic burst(input logic [13:0] code, input int n);
        for (int i = 0; i < n; i++) drive(1'b1, code);
        drive(1'b0, '0);
    endtask

    task automatic do_clear();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        repeat (262) @(negedge clk);
    endtask

    task automatic start_acq(input logic m, input logic r, input int t);
        @(negedge clk);
        start_i = 1'b1; char_mode_i = m; ramp_sel_i = r; target_i = t[19:0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 400 && !done_o; i++) @(negedge clk);
        chk(tag, int'(done_o), 1);
    endtask

    task automatic read_bin(input logic [7:0] a, output int v);
        @(negedge clk); rd_addr_i = a;
        @(negedge clk); v = int'(rd_data_o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int nz;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done after reset", int'(done_o), 0);
        rst_n = 1'b1;
        do_clear();
        // R1: samples while idle are not counted
        burst(14'h0000, 5);
        read_bin(8'h00, v);
        chk("R1 idle samples counted", v, 0);

        // R3 / R4: address table
        for (int k = 0; k < 8; k++) begin
            do_clear();
            start_acq(VEC[k][31], VEC[k][30], 1);
            burst(VEC[k][29:16], 1);
            wait_done("R7 done after single sample");
            read_bin(VEC[k][15:8], v);
            chk(VEC[k][31] ? "R4 selected bin" : "R3 selected bin", v, 1);
            read_bin(VEC[k][7:0], v);
            chk(VEC[k][31] ? "R4 other bin" : "R3 other bin", v, 0);
        end

        // R2: clear with samples arriving, then every word is zero
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        for (int i = 0; i < 262; i++) drive(1'b1, 14'(i * 64));
        drive(1'b0, '0);
        nz = 0;
        for (int a = 0; a < 256; a++) begin
            read_bin(8'(a), v);
            if (v != 0) nz++;
        end
        chk("R2 nonzero words after clear", nz, 0);

        // R5: same bin on consecutive cycles
        do_clear();
        start_acq(1'b0, 1'b0, 5);
        burst(14'h0180, 5);
        wait_done("R7 done after burst");
        read_bin(8'h03, v);
        chk("R5 back-to-back count", v, 5);

        // R5: interleaved bins A B A A B A
        do_clear();
        start_acq(1'b1, 1'b0, 6);
        drive(1'b1, 14'h0000); drive(1'b1, 14'h0040); drive(1'b1, 14'h0000);
        drive(1'b1, 14'h0000); drive(1'b1, 14'h0040); drive(1'b1, 14'h0000);
        drive(1'b0, '0);
        wait_done("R7 done after interleave");
        read_bin(8'h00, v);
        chk("R5 interleave bin A", v, 4);
        read_bin(8'h01, v);
        chk("R5 interleave bin B", v, 2);

        // R8: one-cycle read latency
        @(negedge clk); rd_addr_i = 8'h00;
        @(negedge clk); rd_addr_i = 8'h01;
        chk("R8 data from previous address", int'(rd_data_o), 4);
        @(negedge clk);
        chk("R8 data after next edge", int'(rd_data_o), 2);

        // R7: gapped strobes, surplus ignored, done timing and hold
        do_clear();
        start_acq(1'b1, 1'b0, 3);
        drive(1'b1, 14'h0000); drive(1'b0, 14'h0000);
        repeat (4) @(negedge clk);
        chk("R7 done before target", int'(done_o), 0);
        burst(14'h0000, 4);
        wait_done("R7 done at target");
        repeat (10) @(negedge clk);
        chk("R7 done holds", int'(done_o), 1);
        read_bin(8'h00, v);
        chk("R7 counted samples", v, 3);

        // R9: mode and ramp fixed at start
        do_clear();
        start_acq(1'b0, 1'b1, 1);
        @(negedge clk); char_mode_i = 1'b1; ramp_sel_i = 1'b0;
        burst(14'h2080, 1);
        wait_done("R7 done in capture test");
        read_bin(8'hC1, v);
        chk("R9 captured mapping bin", v, 1);
        read_bin(8'h82, v);
        chk("R9 live-input bin", v, 0);

        // R10: clear during acquisition
        do_clear();
        start_acq(1'b0, 1'b0, 10);
        burst(14'h0000, 3);
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        chk("R10 done after abort", int'(done_o), 0);
        repeat (262) @(negedge clk);
        chk("R10 done after clear pass", int'(done_o), 0);
        read_bin(8'h00, v);
        chk("R10 bin after abort", v, 0);

        // R6: saturation
        do_clear();
        start_acq(1'b1, 1'b0, 65540);
        burst(14'h1000, 65540);
        wait_done("R7 done after long run");
        read_bin(8'h40, v);
        chk("R6 saturated bin", v, 65535);
        read_bin(8'h41, v);
        chk("R6 neighbour bin", v, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule